// File: doc/BRIEF.md
# Paged Program Clock Sequencer

This block runs a small stored program that drives an image-sensor clock generator. The program sits in a four-page memory of 16-bit words. It is made of blocks, and each block has a two-word header followed by two-word entries. Each entry names a waveform-block address and a pixel code, and gives the number of consecutive pixel clocks for which that pair is issued. The header sets how many times the block's entries run as a set. It also sets what happens once they finish: stop, go on to the header that follows, go back to word 0, or move to the first word of a chosen page. Nested loops are built this way without any general instruction set.

Each clock cycle of `clk` is one pixel clock. While `pix_valid` is high, the block issues one waveform address and one pixel code. This holds for data and non-data operations alike. A host loads the program through a simple write port while the sequencer is stopped, then pulses `start`. A misplaced word tag stops execution and raises a sticky error.

Top module: `pixseq_top`

## Requirements
- R1: During and right after reset, `busy`, `err` and `pix_valid` are low.
- R2: A host write (`wr_en` with `wr_addr`, `wr_data`) is stored only while `busy` is low. A write issued while `busy` is high leaves program memory unchanged.
- R3: A block begins with two header words.
  - The first word has tag 11 in bits 15:14, the end action in bits 13:12 and the block repeat count in bits 11:0.
  - The second word has tag 10, a page number in bits 13:12 and the entry count in bits 11:0.
  - The first entry follows at the next word.
- R4: An entry is two words.
  - The first word has tag 01 and the waveform address in bits 13:0.
  - The second word has tag 00, the pixel code in bits 13:11 and the repeat count in bits 10:0.
  - A repeat count N gives N consecutive cycles with `pix_valid` high and the same address and code. N=0 acts as 1.
- R5: A block's entries run in memory order with no idle cycle between them. The whole set runs max(R,1) times, where R is the block repeat count. An entry count of 0 acts as 1.
- R6: The end action codes are:
  - 00: halt. `busy` is low in the cycle where the last emission appears.
  - 01: continue at the header just past the last entry.
  - 10: restart at word 0.
  - 11: jump to word P·2^PAGE_AW, where P is the header's page field.
- R7: A `start` pulse while idle begins execution at word 0, and `busy` is high in the next cycle.
  - `pix_valid` stays low for exactly two cycles after the start edge.
  - Between the last emission of a block and the first emission of the next block there is exactly one cycle with `pix_valid` low.
  - `start` while busy has no effect.
- R8: A word whose tag does not match its position sets `err`, drops `busy` and ends emission. `err` stays set until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin execution at word 0 (idle only) |
| wr_en | input | 1 | Host program write strobe |
| wr_addr | input | PAGE_AW+2 | Host write word address |
| wr_data | input | 16 | Host write data |
| busy | output | 1 | Sequencer running |
| err | output | 1 | Sticky tag-mismatch flag |
| pix_valid | output | 1 | An address/code pair is issued this cycle |
| wave_addr | output | 14 | Waveform-block address |
| pix_code | output | 3 | Pixel code |

## Verification
The bench goes after several corner cases:
- Zero repeat and entry counts, which a design treating 0 as "none" or as 4096 would skip or stretch.
- The idle cycle between blocks, which an off-by-one in the header fetch would drop or double.
- The jump target, which a wrong page shift would send to the wrong word.
- A block set repeated more than once, which a design that reloads the wrong base address would replay from the wrong entry.

Writes and a second `start` are issued in the middle of a run. A design that accepts them would change a later entry's repeat count in the stream. Bad tags are placed both in a header and in a second entry word, to show that execution stops and that the error flag holds until restart.

// File: rtl/pixseq_pkg.sv
package pixseq_pkg;

    localparam int WORD_W  = 16;
    localparam int CNT_W   = 12;
    localparam int REP_W   = 11;
    localparam int WADDR_W = 14;
    localparam int CODE_W  = 3;

    localparam logic [1:0] TAG_H1 = 2'b11;
    localparam logic [1:0] TAG_H2 = 2'b10;
    localparam logic [1:0] TAG_E1 = 2'b01;
    localparam logic [1:0] TAG_E2 = 2'b00;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HDR  = 2'd1,
        S_ENT  = 2'd2,
        S_RUN  = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        ACT_HALT    = 2'b00,
        ACT_NEXT    = 2'b01,
        ACT_RESTART = 2'b10,
        ACT_JUMP    = 2'b11
    } end_act_e;

    typedef struct packed {
        logic             ok;
        end_act_e         act;
        logic [1:0]       page;
        logic [CNT_W-1:0] blk_rep;
        logic [CNT_W-1:0] ent_cnt;
    } hdr_t;

    typedef struct packed {
        logic               ok;
        logic [WADDR_W-1:0] waddr;
        logic [CODE_W-1:0]  code;
        logic [REP_W-1:0]   rep;
    } ent_t;

    function automatic logic [CNT_W-1:0] at_least_one12(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    function automatic logic [REP_W-1:0] at_least_one11(input logic [REP_W-1:0] v);
        return (v == '0) ? REP_W'(1) : v;
    endfunction

endpackage

// File: rtl/pixseq_mem.sv
module pixseq_mem #(
    parameter int AW = 10,
    parameter int DW = 16,
    parameter int NRD = 2
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][DW-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = store[raddr[g]];
    end
endmodule

// File: rtl/pixseq_decode.sv
module pixseq_decode
    import pixseq_pkg::*;
(
    input  logic [WORD_W-1:0] w_lo,
    input  logic [WORD_W-1:0] w_hi,
    output hdr_t              hdr,
    output ent_t              ent
);
    always_comb begin
        hdr.ok      = (w_lo[15:14] == TAG_H1) && (w_hi[15:14] == TAG_H2);
        hdr.act     = end_act_e'(w_lo[13:12]);
        hdr.blk_rep = w_lo[CNT_W-1:0];
        hdr.page    = w_hi[13:12];
        hdr.ent_cnt = w_hi[CNT_W-1:0];

        ent.ok      = (w_lo[15:14] == TAG_E1) && (w_hi[15:14] == TAG_E2);
        ent.waddr   = w_lo[WADDR_W-1:0];
        ent.code    = w_hi[13:11];
        ent.rep     = w_hi[REP_W-1:0];
    end
endmodule

// File: rtl/pixseq_top.sv
module pixseq_top
    import pixseq_pkg::*;
#(
    parameter int PAGE_AW = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    wr_en,
    input  logic [PAGE_AW+1:0]      wr_addr,
    input  logic [WORD_W-1:0]       wr_data,
    output logic                    busy,
    output logic                    err,
    output logic                    pix_valid,
    output logic [WADDR_W-1:0]      wave_addr,
    output logic [CODE_W-1:0]       pix_code
);
    localparam int PC_W = PAGE_AW + 2;
    localparam logic [PC_W-1:0] STEP = PC_W'(2);

    typedef struct packed {
        seq_state_e         st;
        logic [PC_W-1:0]    pc;
        logic [PC_W-1:0]    base;
        logic [CNT_W-1:0]   ent_left;
        logic [CNT_W-1:0]   ent_total;
        logic [CNT_W-1:0]   blk_left;
        logic [REP_W-1:0]   rep_left;
        end_act_e           act;
        logic [1:0]         jpage;
        logic               err;
        logic               ov;
        logic [WADDR_W-1:0] oa;
        logic [CODE_W-1:0]  oc;
    } regs_t;

    regs_t q, d;

    logic [1:0][PC_W-1:0]   rd_addr;
    logic [1:0][WORD_W-1:0] rd_word;
    hdr_t                   hdr;
    ent_t                   ent;
    logic                   emit;
    logic                   fin;
    logic                   run_phase;

    assign rd_addr[0] = q.pc;
    assign rd_addr[1] = q.pc + PC_W'(1);

    pixseq_mem #(.AW(PC_W), .DW(WORD_W), .NRD(2)) u_mem (
        .clk   (clk),
        .we    (wr_en && (q.st == S_IDLE)),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    pixseq_decode u_dec (
        .w_lo (rd_word[0]),
        .w_hi (rd_word[1]),
        .hdr  (hdr),
        .ent  (ent)
    );

    always_comb begin
        d    = q;
        d.ov = 1'b0;
        emit = 1'b0;
        fin  = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.st  = S_HDR;
                    d.pc  = '0;
                    d.err = 1'b0;
                end
            end
            S_HDR: begin
                if (!hdr.ok) begin
                    d.st  = S_IDLE;
                    d.err = 1'b1;
                end else begin
                    d.act       = hdr.act;
                    d.jpage     = hdr.page;
                    d.blk_left  = at_least_one12(hdr.blk_rep) - CNT_W'(1);
                    d.ent_total = at_least_one12(hdr.ent_cnt);
                    d.ent_left  = at_least_one12(hdr.ent_cnt);
                    d.pc        = q.pc + STEP;
                    d.base      = q.pc + STEP;
                    d.st        = S_ENT;
                end
            end
            S_ENT: begin
                if (!ent.ok) begin
                    d.st  = S_IDLE;
                    d.err = 1'b1;
                end else begin
                    emit       = 1'b1;
                    d.oa       = ent.waddr;
                    d.oc       = ent.code;
                    d.rep_left = at_least_one11(ent.rep) - REP_W'(1);
                    if (d.rep_left != '0) begin
                        d.st = S_RUN;
                    end else begin
                        fin = 1'b1;
                    end
                end
            end
            default: begin
                emit       = 1'b1;
                d.rep_left = q.rep_left - REP_W'(1);
                if (d.rep_left == '0) begin
                    fin = 1'b1;
                end
            end
        endcase

        if (emit) begin
            d.ov = 1'b1;
        end

        if (fin) begin
            if (q.ent_left > CNT_W'(1)) begin
                d.ent_left = q.ent_left - CNT_W'(1);
                d.pc       = q.pc + STEP;
                d.st       = S_ENT;
            end else if (q.blk_left != '0) begin
                d.blk_left = q.blk_left - CNT_W'(1);
                d.ent_left = q.ent_total;
                d.pc       = q.base;
                d.st       = S_ENT;
            end else begin
                case (q.act)
                    ACT_HALT: begin
                        d.st = S_IDLE;
                    end
                    ACT_NEXT: begin
                        d.pc = q.pc + STEP;
                        d.st = S_HDR;
                    end
                    ACT_RESTART: begin
                        d.pc = '0;
                        d.st = S_HDR;
                    end
                    default: begin
                        d.pc = {q.jpage, {PAGE_AW{1'b0}}};
                        d.st = S_HDR;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != S_IDLE);
    assign err       = q.err;
    assign pix_valid = q.ov;
    assign wave_addr = q.oa;
    assign pix_code  = q.oc;
    assign run_phase = (q.st == S_RUN);
endmodule

// File: rtl/pixseq_chk.sv
module pixseq_chk
    import pixseq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               err,
    input logic               pix_valid,
    input logic [WADDR_W-1:0] wave_addr,
    input logic [CODE_W-1:0]  pix_code,
    input logic               in_run
);
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !err && !pix_valid));

    p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_valid_needs_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(busy));

    p_run_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_run |=> (pix_valid && $stable(wave_addr) && $stable(pix_code)));

    p_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> err);
endmodule

bind pixseq_top pixseq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .err       (err),
    .pix_valid (pix_valid),
    .wave_addr (wave_addr),
    .pix_code  (pix_code),
    .in_run    (run_phase)
);

// File: tb/pixseq_top_tb.sv
`timescale 1ns/1ps
module pixseq_top_tb;
    localparam int PAGE_AW = 8;
    localparam int DEPTH   = 1 << (PAGE_AW + 2);
    localparam int PAGE_WORDS = 1 << PAGE_AW;
    localparam bit [17:0] GAP = 18'd0;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic                 wr_en = 1'b0;
    logic [PAGE_AW+1:0]   wr_addr = '0;
    logic [15:0]          wr_data = '0;
    logic                 busy, err, pix_valid;
    logic [13:0]          wave_addr;
    logic [2:0]           pix_code;

    int checks = 0;
    int errors = 0;
    logic [15:0] img [DEPTH];
    bit [17:0] exp_q[$];
    bit [17:0] act_q[$];
    bit exp_err;

    always #2.5 clk = ~clk;

    pixseq_top #(.PAGE_AW(PAGE_AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .err(err),
        .pix_valid(pix_valid), .wave_addr(wave_addr), .pix_code(pix_code)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R7 watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    task automatic chk(bit ok, string req, string what, longint actv, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, actv, expv);
        end
    endtask

    function automatic logic [15:0] h1(int act, int rep);
        return {2'b11, 2'(act), 12'(rep)};
    endfunction
    function automatic logic [15:0] h2(int page, int cnt);
        return {2'b10, 2'(page), 12'(cnt)};
    endfunction
    function automatic logic [15:0] e1(int wa);
        return {2'b01, 14'(wa)};
    endfunction
    function automatic logic [15:0] e2(int code, int rep);
        return {2'b00, 3'(code), 11'(rep)};
    endfunction

    task automatic wr(int a, logic [15:0] dat);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = (PAGE_AW+2)'(a);
        wr_data = dat;
        img[a]  = dat;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic build_exp(int limit);
        int pc = 0;
        bit done = 0;
        exp_q.delete();
        exp_err = 0;
        exp_q.push_back(GAP);
        while (!done && exp_q.size() < limit) begin
            logic [15:0] w0 = img[pc];
            logic [15:0] w1 = img[(pc + 1) % DEPTH];
            int brep, cnt, base;
            if (w0[15:14] != 2'b11 || w1[15:14] != 2'b10) begin
                exp_err = 1;
                break;
            end
            brep = int'(w0[11:0]); if (brep == 0) brep = 1;
            cnt  = int'(w1[11:0]); if (cnt == 0) cnt = 1;
            base = (pc + 2) % DEPTH;
            exp_q.push_back(GAP);
            for (int b = 0; b < brep && !done && exp_q.size() < limit; b++) begin
                for (int e = 0; e < cnt && !done; e++) begin
                    int a = (base + 2 * e) % DEPTH;
                    logic [15:0] x0 = img[a];
                    logic [15:0] x1 = img[(a + 1) % DEPTH];
                    int r;
                    if (x0[15:14] != 2'b01 || x1[15:14] != 2'b00) begin
                        exp_err = 1;
                        done = 1;
                    end else begin
                        r = int'(x1[10:0]); if (r == 0) r = 1;
                        for (int k = 0; k < r; k++) exp_q.push_back({1'b1, x0[13:0], x1[13:11]});
                    end
                end
            end
            if (!done) begin
                case (w0[13:12])
                    2'b00: done = 1;
                    2'b01: pc = (base + 2 * cnt) % DEPTH;
                    2'b10: pc = 0;
                    default: pc = int'(w1[13:12]) * PAGE_WORDS;
                endcase
            end
        end
        while (exp_q.size() > limit) void'(exp_q.pop_back());
    endtask

    task automatic run(int limit, bit poke, int paddr, logic [15:0] pdata);
        int n = 0;
        act_q.delete();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R7", "busy after start", busy, 1);
        while ((busy || pix_valid) && act_q.size() < limit && n < 5000) begin
            act_q.push_back(pix_valid ? {1'b1, wave_addr, pix_code} : GAP);
            n++;
            if (poke && n == 2) begin
                wr_en = 1'b1; wr_addr = (PAGE_AW+2)'(paddr); wr_data = pdata; start = 1'b1;
            end
            if (n == 3) begin
                wr_en = 1'b0; start = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0; start = 1'b0;
    endtask

    task automatic compare(string req, int limit);
        build_exp(limit);
        chk(act_q.size() == exp_q.size(), req, "stream length", act_q.size(), exp_q.size());
        for (int i = 0; i < act_q.size() && i < exp_q.size(); i++)
            chk(act_q[i] == exp_q[i], req, $sformatf("token %0d", i), act_q[i], exp_q[i]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !err && !pix_valid, "R1", "reset state", {busy, err, pix_valid}, 0);
    endtask

    task automatic gen_random();
        int pc = 0;
        int nblk = 1 + $urandom % 3;
        bit jmp = ($urandom % 2) == 1;
        for (int b = 0; b < nblk; b++) begin
            int nent = 1 + $urandom % 3;
            int cf = (nent == 1 && ($urandom % 2) == 1) ? 0 : nent;
            int act = (b < nblk - 1) ? 1 : (jmp ? 3 : 0);
            wr(pc, h1(act, $urandom % 3));
            wr(pc + 1, h2(1, cf));
            pc += 2;
            for (int e = 0; e < nent; e++) begin
                wr(pc, e1($urandom % 16384));
                wr(pc + 1, e2($urandom % 8, $urandom % 4));
                pc += 2;
            end
        end
        if (jmp) begin
            wr(PAGE_WORDS, h1(0, 1 + $urandom % 2));
            wr(PAGE_WORDS + 1, h2(0, 1));
            wr(PAGE_WORDS + 2, e1($urandom % 16384));
            wr(PAGE_WORDS + 3, e2($urandom % 8, $urandom % 3));
        end
    endtask

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < DEPTH; i++) img[i] = 16'h0000;
        do_reset();

        // R3 R4 R5 R6: continue, page jump, zero counts, nested repeats
        wr(0, h1(1, 2)); wr(1, h2(0, 2));
        wr(2, e1(14'h0101)); wr(3, e2(1, 3));
        wr(4, e1(14'h0202)); wr(5, e2(2, 0));
        wr(6, h1(3, 0)); wr(7, h2(2, 0));
        wr(8, e1(14'h1303)); wr(9, e2(3, 1));
        wr(512, h1(0, 1)); wr(513, h2(0, 3));
        wr(514, e1(14'h02aa)); wr(515, e2(4, 1));
        wr(516, e1(14'h03bb)); wr(517, e2(5, 2));
        wr(518, e1(14'h00cc)); wr(519, e2(7, 1));
        // R2: write and start in mid-run must be ignored
        run(1000, 1'b1, 517, e2(6, 9));
        compare("R2", 1000);
        chk(err == 1'b0, "R6", "no error after halt", err, 0);
        run(1000, 1'b0, 0, 16'h0);
        compare("R5", 1000);

        // R6 restart: bounded window, then reset
        wr(0, h1(2, 1)); wr(1, h2(0, 1));
        wr(2, e1(14'h0777)); wr(3, e2(2, 2));
        run(20, 1'b0, 0, 16'h0);
        compare("R6", 20);
        do_reset();

        // R8 bad header tag
        wr(0, e1(14'h0001));
        run(100, 1'b0, 0, 16'h0);
        compare("R8", 100);
        chk(err == 1'b1, "R8", "err after bad header", err, 1);
        repeat (5) @(negedge clk);
        chk(err == 1'b1 && !busy, "R8", "err sticky", err, 1);

        // R8 bad second entry
        wr(0, h1(0, 1)); wr(1, h2(0, 2));
        wr(2, e1(14'h0abc)); wr(3, e2(6, 2));
        wr(4, e1(14'h0def)); wr(5, e1(14'h0123));
        run(100, 1'b0, 0, 16'h0);
        compare("R8", 100);
        chk(err == 1'b1, "R8", "err after bad entry", err, 1);

        // R4 R5 R6 R7: random well-formed programs
        for (int t = 0; t < 10; t++) begin
            gen_random();
            run(1000, 1'b0, 0, 16'h0);
            compare("R7", 1000);
            chk(err == 1'b0, "R8", "err cleared by start", err, 0);
        end

        summary();
        $finish;
    end
endmodule